// File: doc/BRIEF.md
# Path Parity Error Event Counter

This block accumulates path parity errors for a receive path that handles one synchronous payload envelope at a time. Once per envelope, upstream logic presents an error mask: the bitwise XOR of the parity byte it computed and the parity byte it received, together with a valid strobe. A mode input selects how each report is counted. In per-bit mode the counter adds the number of erred bits in the mask. In per-frame mode it adds one for any envelope whose mask is nonzero. Computing the parity byte is done elsewhere.

The count is 32 bits wide by default and stops at its maximum value instead of wrapping. A byte-wide host port reads it. A read of the most significant byte returns that byte from the live counter. The same read copies the full count into a holding register and clears the live counter. The remaining bytes are then read from the holding register, so a host always reads one coherent snapshot. An error report that lands in the same cycle as the clearing read becomes the new starting count, so no event is lost.

Top module: `pathParityErrCounter`

## Requirements
- R1: The count is CNT_W bits wide (default 32). It is read as CNT_W/REG_W byte registers. rdSel = NUM_REGS-1 (3 by default) selects bits 31:24, and rdSel = 0 selects bits 7:0. rdData shows the selected byte from the clock edge that samples rdStrobe until the next read.
- R2: With perBitMode = 1, each cycle with errValid = 1 adds the number of ones in errMask (0 to 8) to the count.
- R3: With perBitMode = 0, each cycle with errValid = 1 and a nonzero errMask adds exactly one to the count.
- R4: A read with rdSel = NUM_REGS-1 returns the live counter's top byte and clears the live counter in the same edge.
- R5: After reset, rdData is 0x00 and every byte register reads 0x00.
- R6: The read of the top byte copies the whole live count into a holding register. Reads with any other rdSel return bytes of that holding register, leave it unchanged, and neither clear nor change the live count.
- R7: An error report that arrives in the same cycle as a top-byte read is not lost. The live count after that edge equals that report's increment.
- R8: The count saturates at all ones. Further reports in either mode leave it at all ones until it is read.
- R9: A report with errMask = 0 adds nothing in either mode. When errValid = 0, errMask has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| errMask | input | MASK_W | XOR of computed and received parity byte |
| errValid | input | 1 | One-cycle strobe, one per envelope |
| perBitMode | input | 1 | 1: count erred bits; 0: count erred envelopes |
| rdStrobe | input | 1 | Host register read |
| rdSel | input | SEL_W | Byte register index, 0 = least significant |
| rdData | output | REG_W | Read data, registered |

## Verification
The main bench instance uses CNT_W = 16 and REG_W = 8, which gives two byte registers. With that size, saturation takes about 8200 full-mask reports, so the saturation limit and the behaviour after it can be reached. At this size every one of the 256 mask values is swept in both counting modes, each followed by a clearing read. A second instance with the default 32-bit width and four registers gets the same error stream. That instance confirms the byte ordering across all four registers and the snapshot-and-clear sequence.

// File: rtl/pecPkg.sv
package pecPkg;
  // Strobes from the read-decode control to the counting datapath
  typedef struct packed {
    logic rdEn;        // load rdData this edge
    logic fromLive;    // source byte from the live counter, else from holding
    logic clearLive;   // restart live counter from the current increment
    logic captureHold; // snapshot live counter into holding register
  } pecCtrl_t;
endpackage

// File: rtl/pecIncGen.sv
module pecIncGen #(
  parameter int MASK_W = 8,
  parameter int INC_W  = $clog2(MASK_W + 1)
) (
  input  logic [MASK_W-1:0] errMask,
  input  logic              errValid,
  input  logic              perBitMode,
  output logic [INC_W-1:0]  inc
);
  logic [INC_W-1:0] bitCount;
  logic             anyErr;

  always_comb begin
    bitCount = '0;
    for (int i = 0; i < MASK_W; i++) begin
      bitCount = bitCount + INC_W'(errMask[i]);
    end
  end

  assign anyErr = |errMask;

  always_comb begin
    if (!errValid)       inc = '0;
    else if (perBitMode) inc = bitCount;
    else                 inc = INC_W'(anyErr);
  end
endmodule

// File: rtl/pecCtrl.sv
module pecCtrl
  import pecPkg::*;
#(
  parameter int SEL_W   = 2,
  parameter int MSB_SEL = 3
) (
  input  logic             rdStrobe,
  input  logic [SEL_W-1:0] rdSel,
  output pecCtrl_t         ctrl
);
  logic topRead;

  assign topRead = rdStrobe && (rdSel == SEL_W'(MSB_SEL));

  always_comb begin
    ctrl.rdEn        = rdStrobe;
    ctrl.fromLive    = topRead;
    ctrl.clearLive   = topRead;
    ctrl.captureHold = topRead;
  end
endmodule

// File: rtl/pecDatapath.sv
module pecDatapath
  import pecPkg::*;
#(
  parameter int CNT_W = 32,
  parameter int REG_W = 8,
  parameter int INC_W = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  pecCtrl_t         ctrl,
  input  logic [INC_W-1:0] inc,
  input  logic [SEL_W-1:0] rdSel,
  output logic [REG_W-1:0] rdData,
  output logic [CNT_W-1:0] liveCnt,
  output logic [CNT_W-1:0] holdCnt
);
  logic [CNT_W:0]   sumWide;
  logic [CNT_W-1:0] satSum;
  logic [CNT_W-1:0] liveNext;
  logic [CNT_W-1:0] rdSrc;
  logic [REG_W-1:0] selByte;

  assign sumWide  = {1'b0, liveCnt} + (CNT_W + 1)'(inc);
  assign satSum   = sumWide[CNT_W] ? {CNT_W{1'b1}} : sumWide[CNT_W-1:0];
  assign liveNext = ctrl.clearLive ? CNT_W'(inc) : satSum;

  assign rdSrc   = ctrl.fromLive ? liveCnt : holdCnt;
  assign selByte = rdSrc[rdSel*REG_W +: REG_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveCnt <= '0;
      holdCnt <= '0;
      rdData  <= '0;
    end else begin
      liveCnt <= liveNext;
      if (ctrl.captureHold) holdCnt <= liveCnt;
      if (ctrl.rdEn)        rdData  <= selByte;
    end
  end
endmodule

// File: rtl/pathParityErrCounter.sv
module pathParityErrCounter
  import pecPkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int REG_W  = 8,
  parameter int MASK_W = 8,
  localparam int NUM_REGS = CNT_W / REG_W,
  localparam int SEL_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MASK_W-1:0] errMask,
  input  logic              errValid,
  input  logic              perBitMode,
  input  logic              rdStrobe,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [REG_W-1:0]  rdData
);
  localparam int INC_W   = $clog2(MASK_W + 1);
  localparam int MSB_SEL = NUM_REGS - 1;

  pecCtrl_t         ctrl;
  logic [INC_W-1:0] inc;
  logic [CNT_W-1:0] liveCnt;
  logic [CNT_W-1:0] holdCnt;

  pecIncGen #(.MASK_W(MASK_W), .INC_W(INC_W)) incGen_i (
    .errMask(errMask), .errValid(errValid), .perBitMode(perBitMode), .inc(inc)
  );

  pecCtrl #(.SEL_W(SEL_W), .MSB_SEL(MSB_SEL)) ctrl_i (
    .rdStrobe(rdStrobe), .rdSel(rdSel), .ctrl(ctrl)
  );

  pecDatapath #(.CNT_W(CNT_W), .REG_W(REG_W), .INC_W(INC_W), .SEL_W(SEL_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .inc(inc), .rdSel(rdSel),
    .rdData(rdData), .liveCnt(liveCnt), .holdCnt(holdCnt)
  );
endmodule

// File: rtl/pathParityErrCounter_chk.sv
module pathParityErrCounter_chk #(
  parameter int CNT_W   = 32,
  parameter int MASK_W  = 8,
  parameter int SEL_W   = 2,
  parameter int MSB_SEL = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [MASK_W-1:0] errMask,
  input logic              errValid,
  input logic              perBitMode,
  input logic              rdStrobe,
  input logic [SEL_W-1:0]  rdSel,
  input logic [CNT_W-1:0]  liveCnt,
  input logic [CNT_W-1:0]  holdCnt
);
  localparam logic [CNT_W-1:0] LIVE_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ROOM_LIM = LIVE_MAX - CNT_W'(MASK_W);

  logic msbRead;
  assign msbRead = rdStrobe && (rdSel == SEL_W'(MSB_SEL));

  a_r2_per_bit_add: assert property (@(posedge clk) disable iff (!rstN)
    errValid && perBitMode && !msbRead && (liveCnt <= ROOM_LIM)
    |=> liveCnt == $past(liveCnt) + CNT_W'($countones($past(errMask))));

  a_r3_per_frame_add: assert property (@(posedge clk) disable iff (!rstN)
    errValid && !perBitMode && !msbRead && (liveCnt != LIVE_MAX)
    |=> liveCnt == $past(liveCnt) + CNT_W'($past(errMask) != '0));

  a_r4_clear_on_top_read: assert property (@(posedge clk) disable iff (!rstN)
    msbRead && !errValid |=> liveCnt == '0);

  a_r6_snapshot: assert property (@(posedge clk) disable iff (!rstN)
    msbRead |=> holdCnt == $past(liveCnt));

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    !msbRead |=> $stable(holdCnt));

  a_r7_collide_bits: assert property (@(posedge clk) disable iff (!rstN)
    msbRead && errValid && perBitMode
    |=> liveCnt == CNT_W'($countones($past(errMask))));

  a_r8_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (liveCnt == LIVE_MAX) && !msbRead |=> liveCnt == LIVE_MAX);

  a_r9_no_report: assert property (@(posedge clk) disable iff (!rstN)
    (!errValid || (errMask == '0)) && !msbRead |=> $stable(liveCnt));
endmodule

bind pathParityErrCounter pathParityErrCounter_chk #(
  .CNT_W(CNT_W), .MASK_W(MASK_W), .SEL_W(SEL_W), .MSB_SEL(MSB_SEL)
) chk_i (
  .clk(clk), .rstN(rstN), .errMask(errMask), .errValid(errValid),
  .perBitMode(perBitMode), .rdStrobe(rdStrobe), .rdSel(rdSel),
  .liveCnt(liveCnt), .holdCnt(holdCnt)
);

// File: tb/pathParityErrCounter_tb_top.sv
module pathParityErrCounter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam longint MAX_N = 64'hFFFF;
  localparam longint MAX_W = 64'hFFFF_FFFF;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic       rstN;
  logic [7:0] errMask;
  logic       errValid;
  logic       perBitMode;
  logic       rdStrobeN, rdStrobeW;
  logic       rdSelN;
  logic [1:0] rdSelW;
  logic [7:0] rdDataN, rdDataW;

  pathParityErrCounter #(.CNT_W(16), .REG_W(8), .MASK_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .errMask(errMask), .errValid(errValid),
    .perBitMode(perBitMode), .rdStrobe(rdStrobeN), .rdSel(rdSelN), .rdData(rdDataN)
  );

  pathParityErrCounter dutWide_i (
    .clk(clk), .rstN(rstN), .errMask(errMask), .errValid(errValid),
    .perBitMode(perBitMode), .rdStrobe(rdStrobeW), .rdSel(rdSelW), .rdData(rdDataW)
  );

  int testsRun = 0;
  int testsFailed = 0;
  longint liveN = 0, holdN = 0, liveW = 0, holdW = 0;
  logic [7:0] expRdN = 8'h00, expRdW = 8'h00;

  function automatic longint satAdd(longint a, longint b, longint mx);
    return (a + b > mx) ? mx : a + b;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // One clock cycle of stimulus, entered and left just after a falling edge
  task automatic step(bit v, logic [7:0] m, bit rN, bit sN, bit rW, logic [1:0] sW);
    longint inc;
    errValid = v; errMask = m;
    rdStrobeN = rN; rdSelN = sN; rdStrobeW = rW; rdSelW = sW;
    inc = !v ? 0 : (perBitMode ? longint'($countones(m)) : longint'(m != 0));
    if (rN) begin
      if (sN) begin
        expRdN = 8'(liveN >> 8);
        holdN = liveN; liveN = inc;
      end else begin
        expRdN = 8'(holdN);
        liveN = satAdd(liveN, inc, MAX_N);
      end
    end else liveN = satAdd(liveN, inc, MAX_N);
    if (rW) begin
      if (sW == 2'd3) begin
        expRdW = 8'(liveW >> 24);
        holdW = liveW; liveW = inc;
      end else begin
        expRdW = 8'(holdW >> (8 * sW));
        liveW = satAdd(liveW, inc, MAX_W);
      end
    end else liveW = satAdd(liveW, inc, MAX_W);
    @(posedge clk);
    @(negedge clk);
    errValid = 1'b0; rdStrobeN = 1'b0; rdStrobeW = 1'b0;
  endtask

  task automatic readN(bit sel, string req);
    step(1'b0, 8'h00, 1'b1, sel, 1'b0, 2'd0);
    check(req, rdDataN, expRdN);
  endtask

  task automatic readW(logic [1:0] sel, string req);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, sel);
    check(req, rdDataW, expRdW);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    rstN = 1'b0; errMask = '0; errValid = 1'b0; perBitMode = 1'b0;
    rdStrobeN = 1'b0; rdSelN = 1'b0; rdStrobeW = 1'b0; rdSelW = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R5: reset state
    check("R5 rdData narrow", rdDataN, 8'h00);
    check("R5 rdData wide", rdDataW, 8'h00);
    readN(1'b1, "R5"); readN(1'b0, "R5");
    check("R5 explicit", rdDataN, 8'h00);
    for (int s = 3; s >= 0; s--) begin
      readW(2'(s), "R5");
      check("R5 wide explicit", rdDataW, 8'h00);
    end

    // R2/R3/R9: every mask value in both modes, one report then a clearing read
    for (int md = 0; md < 2; md++) begin
      perBitMode = md[0];
      for (int m = 0; m < 256; m++) begin
        step(1'b1, 8'(m), 1'b0, 1'b0, 1'b0, 2'd0);
        readN(1'b1, (m == 0) ? "R9" : (md == 1 ? "R2" : "R3"));
        readN(1'b0, (m == 0) ? "R9" : (md == 1 ? "R2" : "R3"));
        check((md == 1) ? "R2 arith" : "R3 arith", rdDataN,
              (md == 1) ? 8'($countones(m)) : 8'(m != 0));
      end
    end

    // R9: mask ignored while errValid is low
    readN(1'b1, "R4");
    for (int i = 0; i < 6; i++) begin
      errMask = 8'hFF; errValid = 1'b0;
      @(posedge clk); @(negedge clk);
    end
    readN(1'b1, "R9"); readN(1'b0, "R9");
    check("R9 ignored", rdDataN, 8'h00);

    // R1/R2/R3: accumulation across a mixed stream and modes
    lfsr = 8'h5B;
    for (int i = 0; i < 300; i++) begin
      perBitMode = (i % 3) != 0;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step((i % 5) != 4, lfsr, 1'b0, 1'b0, 1'b0, 2'd0);
    end
    readN(1'b1, "R1"); readN(1'b0, "R1");

    // R6: holding register survives later reports; low reads do not clear
    perBitMode = 1'b1;
    for (int i = 0; i < 40; i++) step(1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 2'd0);
    readN(1'b1, "R6");
    check("R6 top byte", rdDataN, 8'h01);
    for (int i = 0; i < 5; i++) step(1'b1, 8'h03, 1'b0, 1'b0, 1'b0, 2'd0);
    readN(1'b0, "R6");
    check("R6 held low", rdDataN, 8'h40);
    readN(1'b0, "R6");
    readN(1'b1, "R6"); readN(1'b0, "R6");
    check("R6 live unaffected", rdDataN, 8'h0A);

    // R7: report arriving with the clearing read
    for (int i = 0; i < 3; i++) step(1'b1, 8'h81, 1'b0, 1'b0, 1'b0, 2'd0);
    step(1'b1, 8'hF0, 1'b1, 1'b1, 1'b0, 2'd0);
    check("R7 old top", rdDataN, expRdN);
    readN(1'b0, "R7");
    check("R7 old low", rdDataN, 8'h06);
    readN(1'b1, "R7"); readN(1'b0, "R7");
    check("R7 kept", rdDataN, 8'h04);

    // R8: saturation in both modes
    readN(1'b1, "R4");
    perBitMode = 1'b1;
    for (int i = 0; i < 8200; i++) step(1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 2'd0);
    perBitMode = 1'b0;
    for (int i = 0; i < 10; i++) step(1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 2'd0);
    readN(1'b1, "R8");
    check("R8 top", rdDataN, 8'hFF);
    readN(1'b0, "R8");
    check("R8 low", rdDataN, 8'hFF);
    readN(1'b1, "R4");
    check("R4 cleared", rdDataN, 8'h00);

    // R1: default width, byte ordering across four registers
    readW(2'd3, "R4");
    perBitMode = 1'b1;
    for (int i = 0; i < 40; i++) step(1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 2'd0);
    readW(2'd3, "R1"); check("R1 b3", rdDataW, 8'h00);
    readW(2'd2, "R1"); check("R1 b2", rdDataW, 8'h00);
    readW(2'd1, "R1"); check("R1 b1", rdDataW, 8'h01);
    readW(2'd0, "R1"); check("R1 b0", rdDataW, 8'h40);
    readW(2'd3, "R4"); check("R4 wide cleared", rdDataW, 8'h00);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule